// File: doc/BRIEF.md
# Clock-Generator Control Register Slave (I2C)

This block is the serial control port of a clock generator. It sits on a two-wire I2C bus as a slave, keeps seven 8-bit control registers and presents them on a flat output bus, from which the frequency, spread and output-enable logic reads. SCL and SDA are oversampled in the system clock domain. SDA is driven open-drain: the block only ever pulls the line low.

A write transfer has no register pointer. After the address byte, the first two bytes are a command byte and a count byte. Both are acknowledged and both are thrown away. Every later byte fills the registers in order, starting at index 0, until STOP. Bytes that arrive once the last register is filled are acknowledged and dropped.

A read transfer also starts at index 0. It streams the registers upward for as long as the master acknowledges each byte. Past the last register it returns 0xFF.

Top module: `ckc_i2c_regs`

## Requirements
- R1: After reset the register bank holds, from index 0 to 6: 0x00, 0xFF, 0x7F, 0xFF, 0x0F, 0x13, 0x00, and SDA is released (`sda_oe_o` = 0).
- R2: The slave address is 7'h69. The address byte 0xD2 (R/W = 0) opens a write and 0xD3 (R/W = 1) opens a read. The slave acknowledges both.
- R3: For any other address byte the slave gives no acknowledge. It then ignores all bus traffic until the next START, and the registers keep their values.
- R4: The slave acknowledges every byte of a write transfer by pulling SDA low for the ninth clock. It changes SDA only while SCL is low.
- R5: In a write, the two bytes that follow the address byte are acknowledged and change no register, whatever their values.
- R6: The data bytes of a write land in register 0, 1, 2 and upward, in order. Registers that a short write does not reach keep their values.
- R7: Data bytes beyond register 6 are acknowledged and discarded.
- R8: A read returns register 0 first, then the higher indices, each byte MSB first.
- R9: A read that goes past register 6 returns 0xFF for every further byte.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more.
- R11: A repeated START, with or without a STOP before it, restarts address matching, and the next transfer begins at register 0.
- R12: A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 56 | Register bank; register i at bits [8*i+7:8*i] |

## Verification
The bench builds the block with its default parameters: seven registers, the 7'h69 address and two header bytes. With seven registers, a write of eight data bytes crosses the end of the bank, so both the dropped write and the 0xFF read padding are reached with short transfers.

The bench sweeps all 256 address byte values. It also runs several computed data patterns through full, overflowing and short writes, each followed by a read of the whole bank. A repeated START is tested in both directions: after a write it opens a read, and it is also followed by a wrong address.

// File: rtl/ckc_pkg.sv
`timescale 1ns/1ps
package ckc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } ckc_state_e;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h0F;
      5:       return 8'h13;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ckc_line_sync.sv
`timescale 1ns/1ps
module ckc_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);

  localparam int Depth = SYNC_STAGES + 1;

  logic [Depth-1:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[Depth-2:0], scl_i};
      sda_q <= {sda_q[Depth-2:0], sda_i};
    end
  end

  logic scl_s, scl_p, sda_s, sda_p;
  assign scl_s = scl_q[Depth-2];
  assign scl_p = scl_q[Depth-1];
  assign sda_s = sda_q[Depth-2];
  assign sda_p = sda_q[Depth-1];

  assign scl_o      = scl_s;
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/ckc_reg_bank.sv
`timescale 1ns/1ps
module ckc_reg_bank
  import ckc_pkg::*;
#(
  parameter int NUM_REGS = 7,
  localparam int PtrW    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [PtrW-1:0]       wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [PtrW-1:0]       rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[g] <= reg_default(g);
      else if (wr_en_i && wr_idx_i == PtrW'(g))       mem[g] <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = mem[g];
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == PtrW'(i)) rd_data_o = mem[i];
  end

  // R7: the controller never strobes a write past the bank
  p_wr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_idx_i < PtrW'(NUM_REGS));

  // R6: a strobed byte is visible in the addressed register one cycle later
  p_wr_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_o[$past(wr_idx_i)*8 +: 8] == $past(wr_data_i));

endmodule

// File: rtl/ckc_ctrl_fsm.sv
`timescale 1ns/1ps
module ckc_ctrl_fsm
  import ckc_pkg::*;
#(
  parameter int         NUM_REGS  = 7,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         HDR_BYTES = 2,
  localparam int        PtrW      = $clog2(NUM_REGS + 1),
  localparam int        HdrW      = $clog2(HDR_BYTES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_i,
  input  logic            start_i,
  input  logic            stop_i,
  output logic            wr_en_o,
  output logic [PtrW-1:0] ptr_o,
  output logic [7:0]      wr_data_o,
  input  logic [7:0]      rd_data_i,
  output logic            sda_oe_o
);

  ckc_state_e      state_q;
  logic [3:0]      bit_cnt_q;
  logic [7:0]      shreg_q;
  logic            is_addr_q, rd_mode_q, macked_q;
  logic [HdrW-1:0] hdr_cnt_q;
  logic [PtrW-1:0] ptr_q;

  logic byte_done, hdr_done, ptr_room;
  assign byte_done = (state_q == S_RX) && scl_fall_i && (bit_cnt_q == 4'd8);
  assign hdr_done  = (hdr_cnt_q == HdrW'(HDR_BYTES));
  assign ptr_room  = (ptr_q < PtrW'(NUM_REGS));

  assign wr_en_o   = byte_done && !is_addr_q && hdr_done && ptr_room;
  assign wr_data_o = shreg_q;
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      is_addr_q <= 1'b0;
      rd_mode_q <= 1'b0;
      macked_q  <= 1'b0;
      hdr_cnt_q <= '0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
    end else if (stop_i) begin
      state_q  <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state_q   <= S_RX;
      bit_cnt_q <= '0;
      is_addr_q <= 1'b1;
      rd_mode_q <= 1'b0;
      hdr_cnt_q <= '0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      unique case (state_q)
        S_RX: begin
          if (scl_rise_i) begin
            shreg_q   <= {shreg_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (is_addr_q) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                rd_mode_q <= shreg_q[0];
                sda_oe_o  <= 1'b1;
                state_q   <= S_ACK;
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              sda_oe_o <= 1'b1;
              state_q  <= S_ACK;
              if (!hdr_done)     hdr_cnt_q <= hdr_cnt_q + HdrW'(1);
              else if (ptr_room) ptr_q     <= ptr_q + PtrW'(1);
            end
          end
        end
        S_ACK: begin
          if (scl_fall_i) begin
            is_addr_q <= 1'b0;
            bit_cnt_q <= '0;
            if (rd_mode_q) begin
              shreg_q  <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              if (ptr_room) ptr_q <= ptr_q + PtrW'(1);
              state_q  <= S_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall_i) begin
            if (bit_cnt_q == 4'd7) begin
              sda_oe_o <= 1'b0;
              state_q  <= S_MACK;
            end else begin
              shreg_q   <= {shreg_q[6:0], 1'b0};
              sda_oe_o  <= ~shreg_q[6];
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise_i) begin
            macked_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (macked_q) begin
              shreg_q   <= rd_data_i;
              sda_oe_o  <= ~rd_data_i[7];
              bit_cnt_q <= '0;
              if (ptr_room) ptr_q <= ptr_q + PtrW'(1);
              state_q   <= S_TX;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_idle_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE |-> !sda_oe_o);

  p_stop_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == S_IDLE && !sda_oe_o);

  p_start_rearm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> state_q == S_RX && is_addr_q && ptr_q == '0);

  p_sda_steady_scl_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(sda_oe_o));

  p_mack_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_MACK |-> !sda_oe_o);

endmodule

// File: rtl/ckc_i2c_regs.sv
`timescale 1ns/1ps
module ckc_i2c_regs #(
  parameter int         NUM_REGS    = 7,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         HDR_BYTES   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int PtrW = $clog2(NUM_REGS + 1);

  logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic wr_en;
  logic [PtrW-1:0] ptr;
  logic [7:0] wr_data, rd_data;

  ckc_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det)
  );

  ckc_ctrl_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES)) i_fsm (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start_det), .stop_i(stop_det),
    .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data), .rd_data_i(rd_data),
    .sda_oe_o
  );

  ckc_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(ptr), .wr_data_i(wr_data),
    .rd_idx_i(ptr), .rd_data_o(rd_data), .regs_o
  );

endmodule

// File: tb/test_ckc_i2c_regs.sv
`timescale 1ns/1ps
module test_ckc_i2c_regs;

  localparam int N = 7;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [N*8-1:0] regs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expv [N];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  ckc_i2c_regs i_ckc_i2c_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic q_wait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      q_wait(1); sda_m = 1'b1; q_wait(1); scl_m = 1'b1; q_wait(1);
    end
    sda_m = 1'b0; q_wait(1); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    q_wait(1); sda_m = 1'b0; q_wait(1); scl_m = 1'b1; q_wait(1); sda_m = 1'b1; q_wait(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      q_wait(1); sda_m = b[i]; q_wait(1); scl_m = 1'b1; q_wait(2); scl_m = 1'b0;
    end
    q_wait(1); sda_m = 1'b1; q_wait(1); scl_m = 1'b1; q_wait(1);
    ack = !sda_line;
    q_wait(1); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      q_wait(1); sda_m = 1'b1; q_wait(1); scl_m = 1'b1; q_wait(1);
      v[i] = sda_line;
      q_wait(1); scl_m = 1'b0;
    end
    q_wait(1); sda_m = !give_ack; q_wait(1); scl_m = 1'b1; q_wait(2); scl_m = 1'b0;
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < N; i++) chk(req, regs[i*8 +: 8], expv[i]);
  endtask

  // open a write, send both header bytes
  task automatic open_write(input logic [7:0] h0, input logic [7:0] h1);
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk("R2 write address ack", a, 1);
    send_byte(h0, a);    chk("R5 header byte0 ack", a, 1);
    send_byte(h1, a);    chk("R5 header byte1 ack", a, 1);
  endtask

  task automatic read_all(input string req, input int count);
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD3, a); chk("R2 read address ack", a, 1);
    for (int i = 0; i < count; i++) begin
      recv_byte(i != count - 1, v);
      chk(req, v, (i < N) ? expv[i] : 8'hFF);
    end
    q_wait(1);
    chk("R10 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] v;
    expv[0] = 8'h00; expv[1] = 8'hFF; expv[2] = 8'h7F; expv[3] = 8'hFF;
    expv[4] = 8'h0F; expv[5] = 8'h13; expv[6] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_bank("R1 reset value");
    chk("R1 sda released", sda_oe, 0);
    read_all("R8 read of defaults", N);

    // R2/R3 address sweep
    for (int ab = 0; ab < 256; ab++) begin
      bus_start();
      send_byte(8'(ab), a);
      if (ab[7:1] == 7'h69) begin
        chk("R2 own address ack", a, 1);
        if (ab[0]) recv_byte(1'b0, v);
      end else begin
        chk("R3 foreign address nack", a, 0);
        send_byte(8'h00, a);
        chk("R3 following byte ignored", a, 0);
      end
      bus_stop();
      chk("R12 idle after stop", sda_oe, 0);
    end
    check_bank("R3 bank unchanged after sweep");

    // R4-R9 full and overflowing writes with computed patterns
    for (int p = 0; p < 6; p++) begin
      open_write(8'(p * 29 + 3), 8'(~(p * 17)));
      for (int i = 0; i < N + 2; i++) begin
        logic [7:0] d;
        d = 8'((p * 37 + i * 11 + 5) & 8'hFF);
        send_byte(d, a);
        if (i < N) begin
          chk("R4 data byte ack", a, 1);
          expv[i] = d;
        end else begin
          chk("R7 overflow byte ack", a, 1);
        end
      end
      bus_stop();
      check_bank("R6 sequential write / R5 header dropped / R7 overflow dropped");
      read_all("R9 read past bank / R8 ordered read", N + 3);
    end

    // R6 short writes leave the tail intact
    for (int n = 0; n < 4; n++) begin
      open_write(8'hAA, 8'h55);
      for (int i = 0; i < n; i++) begin
        send_byte(8'(8'hC0 + n * 4 + i), a);
        chk("R4 short write ack", a, 1);
        expv[i] = 8'(8'hC0 + n * 4 + i);
      end
      bus_stop();
      check_bank("R6 short write");
    end

    // R11 repeated start: write then read without STOP
    open_write(8'h00, 8'h07);
    send_byte(8'h5A, a); chk("R4 data ack", a, 1); expv[0] = 8'h5A;
    send_byte(8'hA5, a); chk("R4 data ack", a, 1); expv[1] = 8'hA5;
    bus_start();
    send_byte(8'hD3, a); chk("R11 read after repeated start ack", a, 1);
    recv_byte(1'b1, v); chk("R11 read restarts at reg0", v, 8'h5A);
    recv_byte(1'b0, v); chk("R11 second byte", v, 8'hA5);
    q_wait(1); chk("R10 released after nack", sda_oe, 0);
    // R11 repeated start to a foreign address
    bus_start();
    send_byte(8'hD4, a); chk("R11 foreign address after rstart nack", a, 0);
    send_byte(8'h33, a); chk("R3 ignored byte", a, 0);
    bus_start();
    send_byte(8'hD2, a); chk("R11 rematch after rstart", a, 1);
    send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h3C, a); chk("R11 write restarts at reg0", a, 1); expv[0] = 8'h3C;
    bus_stop();
    check_bank("R11 bank after repeated starts");
    read_all("R8 final read", N + 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule